// File: doc/BRIEF.md
# Fixed-Latency Load/Store Memory with Queued Ports

This block models a word-addressed on-chip memory that a pipelined core reaches through queue-style ports instead of a combinational read path. A client pushes requests through a ready/valid enqueue port. Each request carries a direction bit (store or load), a word address and write data. Requests wait in a small request queue and are applied to the storage array one per cycle, strictly in the order they were accepted. A store writes the array and produces nothing further. A load reads the array, travels through a delay line of fixed depth, and lands in a response queue. The client reads the response queue through a head-of-queue valid/data pair and pops it with a ready strobe.

The delay line never stalls. The block keeps a count of the loads in flight and the responses still queued, and lets a load leave the request queue only while that count is below the response queue capacity, so the response queue can never overflow. When loads are blocked this way, the request queue fills and the enqueue port drops its ready. A store waiting behind a blocked load also waits, which preserves the order in which requests take effect.

Top module: `latmem`

## Requirements
- R1: After reset, `reqReady` is 1 and `rspValid` is 0.
- R2: In an idle block, a load accepted at clock edge k is at the head of the response port (`rspValid` = 1) right after edge k+LATENCY+1 and not earlier: one cycle in the request queue, then LATENCY cycles in the delay line. LATENCY is at least 2.
- R3: A store request (`reqIsStore` = 1) writes `reqWrData` to word `reqAddr` and produces no response entry.
- R4: Each accepted load (`reqIsStore` = 0) produces exactly one response entry.
- R5: Responses leave in the order their loads were accepted.
- R6: A load returns the value of the most recent store to its address accepted before it, including a store accepted in the immediately preceding cycle.
- R7: With the response port stalled, the loads in flight plus the queued responses never exceed RESP_DEPTH; once RESP_DEPTH loads are held, further requests fill the request queue and `reqReady` falls, and no response is lost once the port resumes.
- R8: While `rspValid` is 1 and `rspReady` is 0, `rspValid` stays 1 and `rspData` holds its value on the next cycle.
- R9: Synchronous active-high reset empties the request queue, the delay line and the response queue; the storage array keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | The request queue has room; request accepted when both are 1 |
| reqIsStore | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Word address |
| reqWrData | input | DATA_W | Store data, ignored for loads |
| rspValid | output | 1 | A load response is at the head of the response queue |
| rspReady | input | 1 | Pops the head response when `rspValid` is 1 |
| rspData | output | DATA_W | Data of the head response |

## Verification
A load's response is due LATENCY+1 edges after its acceptance edge when the block is idle, so the bench counts edges from the acceptance and checks that `rspValid` is low at every sample before that point and high exactly at it. All inputs are driven and all outputs are sampled shortly after the falling edge, so a handshake seen in a sample is the one that completes on the next rising edge, and the reference model updates its shadow memory and expected-response queue at that moment. Under random stimulus with stall phases, each popped response is compared with the head of the model's queue, and a response with nothing expected is a failure. The backpressure test counts accepted loads while the response port is held stalled and expects exactly RESP_DEPTH plus REQ_DEPTH before `reqReady` drops.

// File: rtl/latmem_pkg.sv
package latmem_pkg;

  typedef struct packed {
    logic reqPush;
    logic reqPop;
    logic issueStore;
    logic issueLoad;
    logic rspPush;
    logic rspPop;
  } ctlStrobes_t;

endpackage

// File: rtl/latmem_ctrl.sv
module latmem_ctrl
  import latmem_pkg::*;
#(
  parameter int REQ_DEPTH  = 2,
  parameter int RESP_DEPTH = 4,
  parameter int LATENCY    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic reqValid,
  output logic reqReady,
  input  logic headLoad,
  input  logic rspReady,
  output logic rspValid,
  output ctlStrobes_t strobes,
  output logic [$clog2(REQ_DEPTH)-1:0]  reqWrPtr,
  output logic [$clog2(REQ_DEPTH)-1:0]  reqRdPtr,
  output logic [$clog2(RESP_DEPTH)-1:0] rspWrPtr,
  output logic [$clog2(RESP_DEPTH)-1:0] rspRdPtr
);

  localparam int RQ_AW = $clog2(REQ_DEPTH);
  localparam int RS_AW = $clog2(RESP_DEPTH);
  localparam int RQ_CW = $clog2(REQ_DEPTH + 1);
  localparam int RS_CW = $clog2(RESP_DEPTH + 1);
  localparam logic [RQ_CW-1:0] REQ_FULL  = RQ_CW'(REQ_DEPTH);
  localparam logic [RS_CW-1:0] RSP_FULL  = RS_CW'(RESP_DEPTH);
  localparam logic [RQ_CW-1:0] RQ_ONE    = RQ_CW'(1);
  localparam logic [RS_CW-1:0] RS_ONE    = RS_CW'(1);
  localparam logic [RQ_AW-1:0] RQ_PSTEP  = RQ_AW'(1);
  localparam logic [RS_AW-1:0] RS_PSTEP  = RS_AW'(1);

  logic [RQ_CW-1:0]   reqCount;
  logic [RS_CW-1:0]   rspCount;
  logic [RS_CW-1:0]   credits;
  logic [LATENCY-1:0] pipeValid;
  logic               canIssue;

  // request side
  assign reqReady         = (reqCount != REQ_FULL);
  assign strobes.reqPush  = reqValid && reqReady;

  // a load may leave the request queue only while a response slot is reserved for it
  assign canIssue           = (reqCount != '0) && (!headLoad || (credits < RSP_FULL));
  assign strobes.reqPop     = canIssue;
  assign strobes.issueLoad  = canIssue && headLoad;
  assign strobes.issueStore = canIssue && !headLoad;

  // response side
  assign strobes.rspPush = pipeValid[LATENCY-1];
  assign rspValid        = (rspCount != '0);
  assign strobes.rspPop  = rspValid && rspReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      reqCount  <= '0;
      reqWrPtr  <= '0;
      reqRdPtr  <= '0;
      rspCount  <= '0;
      rspWrPtr  <= '0;
      rspRdPtr  <= '0;
      credits   <= '0;
      pipeValid <= '0;
    end else begin
      pipeValid <= {pipeValid[LATENCY-2:0], strobes.issueLoad};

      if (strobes.reqPush) reqWrPtr <= reqWrPtr + RQ_PSTEP;
      if (strobes.reqPop)  reqRdPtr <= reqRdPtr + RQ_PSTEP;
      case ({strobes.reqPush, strobes.reqPop})
        2'b10:   reqCount <= reqCount + RQ_ONE;
        2'b01:   reqCount <= reqCount - RQ_ONE;
        default: reqCount <= reqCount;
      endcase

      if (strobes.rspPush) rspWrPtr <= rspWrPtr + RS_PSTEP;
      if (strobes.rspPop)  rspRdPtr <= rspRdPtr + RS_PSTEP;
      case ({strobes.rspPush, strobes.rspPop})
        2'b10:   rspCount <= rspCount + RS_ONE;
        2'b01:   rspCount <= rspCount - RS_ONE;
        default: rspCount <= rspCount;
      endcase

      case ({strobes.issueLoad, strobes.rspPop})
        2'b10:   credits <= credits + RS_ONE;
        2'b01:   credits <= credits - RS_ONE;
        default: credits <= credits;
      endcase
    end
  end

  AST_CREDIT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    credits <= RSP_FULL);  // R7
  AST_NO_RSP_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    strobes.rspPush |-> (rspCount != RSP_FULL) || strobes.rspPop);  // R7
  AST_NO_REQ_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    strobes.reqPush |-> (reqCount != REQ_FULL));  // R7
  AST_RSP_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
    strobes.rspPush |-> (credits != '0));  // R3
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rspValid && !rspReady |=> rspValid);  // R8

endmodule

// File: rtl/latmem_dpath.sv
module latmem_dpath
  import latmem_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int REQ_DEPTH  = 2,
  parameter int RESP_DEPTH = 4,
  parameter int LATENCY    = 3
) (
  input  logic clk,
  input  logic rst,
  input  ctlStrobes_t strobes,
  input  logic [$clog2(REQ_DEPTH)-1:0]  reqWrPtr,
  input  logic [$clog2(REQ_DEPTH)-1:0]  reqRdPtr,
  input  logic [$clog2(RESP_DEPTH)-1:0] rspWrPtr,
  input  logic [$clog2(RESP_DEPTH)-1:0] rspRdPtr,
  input  logic              reqIsStore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              headLoad,
  input  logic              rspValid,
  input  logic              rspReady,
  output logic [DATA_W-1:0] rspData
);

  localparam int WORDS = 1 << ADDR_W;

  typedef struct packed {
    logic              isStore;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } reqEntry_t;

  reqEntry_t         reqQ     [REQ_DEPTH];
  logic [DATA_W-1:0] memArray [WORDS];
  logic [DATA_W-1:0] pipeData [LATENCY];
  logic [DATA_W-1:0] rspQ     [RESP_DEPTH];
  reqEntry_t         head;

  assign head     = reqQ[reqRdPtr];
  assign headLoad = !head.isStore;
  assign rspData  = rspQ[rspRdPtr];

  always_ff @(posedge clk) begin
    if (strobes.reqPush) reqQ[reqWrPtr] <= '{isStore: reqIsStore, addr: reqAddr, data: reqWrData};
  end

  // storage array: one request applied per cycle, in acceptance order
  always_ff @(posedge clk) begin
    if (strobes.issueStore) memArray[head.addr] <= head.data;
  end

  always_ff @(posedge clk) begin
    pipeData[0] <= memArray[head.addr];
  end

  for (genvar g = 1; g < LATENCY; g++) begin : g_delay
    always_ff @(posedge clk) pipeData[g] <= pipeData[g-1];
  end

  always_ff @(posedge clk) begin
    if (strobes.rspPush) rspQ[rspWrPtr] <= pipeData[LATENCY-1];
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    rspValid && !rspReady |=> $stable(rspData));  // R8

endmodule

// File: rtl/latmem.sv
module latmem
  import latmem_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int REQ_DEPTH  = 2,
  parameter int RESP_DEPTH = 4,
  parameter int LATENCY    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqIsStore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [DATA_W-1:0] rspData
);

  localparam int RQ_AW = $clog2(REQ_DEPTH);
  localparam int RS_AW = $clog2(RESP_DEPTH);

  ctlStrobes_t      strobes;
  logic             headLoad;
  logic [RQ_AW-1:0] reqWrPtr, reqRdPtr;
  logic [RS_AW-1:0] rspWrPtr, rspRdPtr;

  latmem_ctrl #(
    .REQ_DEPTH(REQ_DEPTH), .RESP_DEPTH(RESP_DEPTH), .LATENCY(LATENCY)
  ) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .headLoad(headLoad), .rspReady(rspReady), .rspValid(rspValid),
    .strobes(strobes), .reqWrPtr(reqWrPtr), .reqRdPtr(reqRdPtr),
    .rspWrPtr(rspWrPtr), .rspRdPtr(rspRdPtr)
  );

  latmem_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REQ_DEPTH(REQ_DEPTH),
    .RESP_DEPTH(RESP_DEPTH), .LATENCY(LATENCY)
  ) u_dpath (
    .clk(clk), .rst(rst), .strobes(strobes),
    .reqWrPtr(reqWrPtr), .reqRdPtr(reqRdPtr),
    .rspWrPtr(rspWrPtr), .rspRdPtr(rspRdPtr),
    .reqIsStore(reqIsStore), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .headLoad(headLoad), .rspValid(rspValid), .rspReady(rspReady),
    .rspData(rspData)
  );

endmodule

// File: tb/latmem_bench.sv
module latmem_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 16;
  localparam int REQ_DEPTH  = 2;
  localparam int RESP_DEPTH = 4;
  localparam int LATENCY    = 3;
  localparam int WORDS      = 1 << ADDR_W;
  localparam int QSZ        = 1024;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqIsStore = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWrData = '0;
  logic              rspValid;
  logic              rspReady = 1'b0;
  logic [DATA_W-1:0] rspData;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [DATA_W-1:0] shadow [WORDS];
  logic [DATA_W-1:0] expQ   [QSZ];
  int expHead = 0;
  int expTail = 0;
  int accepted = 0;

  latmem #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REQ_DEPTH(REQ_DEPTH),
    .RESP_DEPTH(RESP_DEPTH), .LATENCY(LATENCY)
  ) u_latmem (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsStore(reqIsStore), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
      finishRun();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // drive one cycle's inputs after the falling edge and account for the handshakes
  // that will complete on the next rising edge
  task automatic tick(input logic v, input logic st, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic rr);
    @(negedge clk);
    reqValid = v; reqIsStore = st; reqAddr = a; reqWrData = d; rspReady = rr;
    #1;
    if (!rst && rspValid && rspReady) begin
      if (expHead == expTail) begin
        chk(1'b0, "R3 R4 response with no load outstanding", 32'(rspData), 32'hx);
      end else begin
        chk(rspData === expQ[expHead % QSZ], "R5 R6 response data/order",
            32'(rspData), 32'(expQ[expHead % QSZ]));
        expHead++;
      end
    end
    if (!rst && reqValid && reqReady) begin
      accepted++;
      if (st) shadow[a] = d;
      else begin
        expQ[expTail % QSZ] = shadow[a];
        expTail++;
      end
    end
  endtask

  task automatic idle(input int n, input logic rr);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, '0, '0, rr);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && expHead != expTail; i++) tick(1'b0, 1'b0, '0, '0, 1'b1);
    chk(expHead == expTail, "R4 all loads answered", 32'(expTail - expHead), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk(reqReady == 1'b1, "R1 reqReady after reset", 32'(reqReady), 32'd1);
    chk(rspValid == 1'b0, "R1 rspValid after reset", 32'(rspValid), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // fill every word so later loads have defined data; R3: no responses from stores
    for (int i = 0; i < WORDS; i++) begin
      tick(1'b1, 1'b1, ADDR_W'(i), DATA_W'(16'h1000 + i * 7), 1'b1);
      chk(rspValid == 1'b0, "R3 store produced a response", 32'(rspValid), 32'd0);
    end
    for (int i = 0; i < LATENCY + 4; i++) begin
      tick(1'b0, 1'b0, '0, '0, 1'b1);
      chk(rspValid == 1'b0, "R3 store produced a response", 32'(rspValid), 32'd0);
    end

    // R2: exact load latency in an idle block
    tick(1'b1, 1'b0, ADDR_W'(5), '0, 1'b0);
    for (int i = 1; i <= LATENCY + 1; i++) begin
      tick(1'b0, 1'b0, '0, '0, 1'b0);
      chk(rspValid == 1'b0, "R2 response too early", 32'(rspValid), 32'd0);
    end
    tick(1'b0, 1'b0, '0, '0, 1'b1);
    chk(rspValid == 1'b1, "R2 response due", 32'(rspValid), 32'd1);
    idle(2, 1'b1);

    // R6: store then load of the same word on back-to-back cycles
    tick(1'b1, 1'b1, ADDR_W'(7), 16'hBEEF, 1'b1);
    tick(1'b1, 1'b0, ADDR_W'(7), '0, 1'b1);
    tick(1'b1, 1'b1, ADDR_W'(7), 16'h0123, 1'b1);
    tick(1'b1, 1'b0, ADDR_W'(7), '0, 1'b1);
    tick(1'b1, 1'b1, ADDR_W'(7), 16'hBEEF, 1'b1);
    drain();

    // R7 and R8: stalled response port fills credits, then the request queue
    accepted = 0;
    for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, ADDR_W'(i), '0, 1'b0);
    chk(accepted == RESP_DEPTH + REQ_DEPTH, "R7 loads accepted while stalled",
        32'(accepted), 32'(RESP_DEPTH + REQ_DEPTH));
    chk(reqReady == 1'b0, "R7 reqReady low when full", 32'(reqReady), 32'd0);
    begin
      logic [DATA_W-1:0] held;
      held = rspData;
      chk(rspValid == 1'b1, "R8 rspValid while stalled", 32'(rspValid), 32'd1);
      idle(3, 1'b0);
      chk(rspValid == 1'b1 && rspData == held, "R8 data held while stalled",
          32'(rspData), 32'(held));
    end
    drain();

    // R9: reset with loads in flight empties queues but keeps the array
    tick(1'b1, 1'b0, ADDR_W'(1), '0, 1'b0);
    tick(1'b1, 1'b0, ADDR_W'(2), '0, 1'b0);
    tick(1'b1, 1'b0, ADDR_W'(3), '0, 1'b0);
    idle(3, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    idle(2, 1'b0);
    chk(rspValid == 1'b0, "R9 response queue emptied", 32'(rspValid), 32'd0);
    chk(reqReady == 1'b1, "R9 request queue emptied", 32'(reqReady), 32'd1);
    expHead = expTail;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < LATENCY + 3; i++) begin
      tick(1'b0, 1'b0, '0, '0, 1'b1);
      chk(rspValid == 1'b0, "R9 no stale response after reset", 32'(rspValid), 32'd0);
    end
    tick(1'b1, 1'b0, ADDR_W'(7), '0, 1'b1);   // array kept 16'hBEEF
    drain();

    // random mix with stall phases
    for (int i = 0; i < 4000; i++) begin
      logic rr;
      logic v;
      rr = ((i / 200) % 3 == 2) ? ($urandom % 8 == 0) : ($urandom % 4 != 0);
      v  = ($urandom % 4 != 0);
      tick(v, ($urandom % 3 == 0), ADDR_W'($urandom % 16), DATA_W'($urandom), rr);
    end
    drain();
    idle(LATENCY + 2, 1'b1);
    chk(rspValid == 1'b0, "R4 no extra responses", 32'(rspValid), 32'd0);

    finishRun();
  end

endmodule